// File: doc/BRIEF.md
# Multifunction Integer ALU with Pre-Extended Right Shifter

This block is a purely combinational 32-bit arithmetic and logic unit. It is meant to sit in the execute stage of a simple processor datapath. One of four functional units drives the result. The logic unit does AND, OR, NOR and XOR. The arithmetic unit adds or subtracts. The signed set-less-than path is the third, and a barrel shifter is the fourth. The block also reports whether the result is all zeros, and it flags signed overflow for the operations where overflow has a meaning.

The shifter does every shift as a right shift. The data word is first widened to 63 bits, and the fill depends on the shift kind:
- zeros above the word for a logical right shift;
- copies of the sign bit above the word for an arithmetic right shift;
- the low 31 data bits above the word for a rotate right;
- 31 zeros below the word for a left shift.

The widened word then passes through five conditional stages, which move it right by 16, 8, 4, 2 and 1 places. A left shift by k uses the bitwise complement of the amount, which is a right shift by 31-k. The low 32 bits of the last stage are the shift result.

Internally, a small decoder turns the select fields into a struct of strobes, and a datapath module consumes those strobes.

Top module: `mfalu`

## Requirements
- R1: With `unitSel`=11 the result is the bitwise function of `opA` and `opB` chosen by `logicSel`: 00 AND, 01 OR, 10 NOR, 11 XOR.
- R2: With `unitSel`=10 the result is `opA`+`opB` (modulo 2^32) when `subSel`=0, and `opA`-`opB` when `subSel`=1.
- R3: `unitSel` picks the source of `result`: 00 shifter, 01 set-less-than, 10 add/subtract, 11 logic unit.
- R4: With `unitSel`=01 the result is 1 when `opA` is less than `opB` as signed numbers and 0 otherwise, with bits 31..1 always zero. The decision is the sign of `opA`-`opB` XOR its overflow. `subSel` has no effect in this unit.
- R5: `ovfFlag` is 1 only for `unitSel` 10 or 01. It is set when the two addends of the effective addition (`opB` inverted for a subtraction) have equal signs and the sum's sign differs from them. For `unitSel` 00 or 11 it is always 0.
- R6: `zeroFlag` is 1 exactly when all 32 bits of `result` are 0, whichever unit is selected.
- R7: With `unitSel`=00 and `shiftSel`=00, the result is `opA` shifted left by `shAmt`, with zeros entering at the bottom.
- R8: With `unitSel`=00 and `shiftSel`=10, the result is `opA` shifted right by `shAmt`, with zeros entering at the top.
- R9: With `unitSel`=00 and `shiftSel`=01, the result is `opA` shifted right by `shAmt`, with copies of bit 31 entering at the top.
- R10: With `unitSel`=00 and `shiftSel`=11, the result is `opA` rotated right by `shAmt`. An amount of 0 returns `opA` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand, and the data word for shifts |
| opB | input | 32 | Second operand |
| shAmt | input | 5 | Shift or rotate amount |
| unitSel | input | 2 | Functional unit driving the result |
| logicSel | input | 2 | Bitwise function for the logic unit |
| shiftSel | input | 2 | Shift kind: 00 left, 01 arithmetic right, 10 logical right, 11 rotate right |
| subSel | input | 1 | 0 add, 1 subtract, in the arithmetic unit |
| result | output | 32 | Selected unit output |
| zeroFlag | output | 1 | All bits of result are zero |
| ovfFlag | output | 1 | Signed overflow of add, subtract or compare |

## Verification
The block holds no state, so a wrong internal value reaches the ports within the same evaluation as the inputs that caused it.

Each kind of fault leaves its own mark:
- **Stuck shifter stage.** A stage that is stuck taken or untaken gives a result displaced by exactly its power of two. This shows only for amounts whose matching bit differs, so the amounts are swept across all 32 values.
- **Wrong extension fill.** The error appears only in vacated bit positions, and only for nonzero amounts.
- **Wrong carry-in or operand inversion.** This gives sums off by one, or sums of the wrong sign.
- **Overflow or set-less-than fault.** These show only near the signed limits, which directed operands at 0x7FFFFFFF and 0x80000000 cover.

// File: rtl/mfalu_pkg.sv
package mfalu_pkg;

  typedef enum logic [1:0] {
    UNIT_SHIFT = 2'b00,
    UNIT_SLT   = 2'b01,
    UNIT_ARITH = 2'b10,
    UNIT_LOGIC = 2'b11
  } unit_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'b00,
    LOG_OR  = 2'b01,
    LOG_NOR = 2'b10,
    LOG_XOR = 2'b11
  } logic_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'b00,
    SH_ARITH = 2'b01,
    SH_LOGIC = 2'b10,
    SH_ROT   = 2'b11
  } shift_e;

  // How the shifter widens its data word before right shifting
  typedef enum logic [1:0] {
    EXT_ZERO   = 2'b00,  // zeros above the word
    EXT_SIGN   = 2'b01,  // sign copies above the word
    EXT_WRAP   = 2'b10,  // low bits of the word above it
    EXT_LOWPAD = 2'b11   // zeros below the word
  } ext_e;

  // One-hot result pick positions
  localparam int PICK_SHIFT = 0;
  localparam int PICK_SLT   = 1;
  localparam int PICK_ARITH = 2;
  localparam int PICK_LOGIC = 3;
  localparam int PICK_N     = 4;

  typedef struct packed {
    logic              invB;
    logic              carryIn;
    logic              amtInvert;
    ext_e              extMode;
    logic [PICK_N-1:0] pick;
    logic_e            logicOp;
    logic              ovfEnable;
  } strobe_t;

endpackage

// File: rtl/mfalu_ctrl.sv
module mfalu_ctrl
  import mfalu_pkg::*;
(
  input  logic [1:0] unitSel,
  input  logic [1:0] logicSel,
  input  logic [1:0] shiftSel,
  input  logic       subSel,
  output strobe_t    strobes
);

  always_comb begin
    strobes           = '0;
    strobes.extMode   = EXT_ZERO;
    strobes.logicOp   = logic_e'(logicSel);
    unique case (unit_e'(unitSel))
      UNIT_SHIFT: begin
        strobes.pick[PICK_SHIFT] = 1'b1;
        unique case (shift_e'(shiftSel))
          SH_LEFT: begin
            strobes.extMode   = EXT_LOWPAD;
            strobes.amtInvert = 1'b1;
          end
          SH_ARITH: strobes.extMode = EXT_SIGN;
          SH_LOGIC: strobes.extMode = EXT_ZERO;
          SH_ROT:   strobes.extMode = EXT_WRAP;
          default:  strobes.extMode = EXT_ZERO;
        endcase
      end
      UNIT_SLT: begin
        strobes.pick[PICK_SLT] = 1'b1;
        strobes.invB           = 1'b1;
        strobes.carryIn        = 1'b1;
        strobes.ovfEnable      = 1'b1;
      end
      UNIT_ARITH: begin
        strobes.pick[PICK_ARITH] = 1'b1;
        strobes.invB             = subSel;
        strobes.carryIn          = subSel;
        strobes.ovfEnable        = 1'b1;
      end
      UNIT_LOGIC: strobes.pick[PICK_LOGIC] = 1'b1;
      default:    strobes.pick = '0;
    endcase
  end

endmodule

// File: rtl/mfalu_addsub.sv
module mfalu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             invB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             ovf
);

  logic [WIDTH-1:0] bEff;

  always_comb begin
    bEff = invB ? ~b : b;
    sum  = a + bEff + WIDTH'(carryIn);
    ovf  = (a[WIDTH-1] == bEff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
  end

  // R2: a subtraction undone by adding b back must restore a
  always_comb begin
    a_r2_sub_inverse: assert (!(invB && carryIn) || ((sum + b) == a))
      else $error("a_r2_sub_inverse: difference plus b does not return a");
  end

endmodule

// File: rtl/mfalu_shifter.sv
module mfalu_shifter
  import mfalu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(WIDTH),
  localparam int PAD  = WIDTH - 1,
  localparam int EW   = WIDTH + PAD
) (
  input  logic [WIDTH-1:0] data,
  input  logic [AW-1:0]    amt,
  input  logic             amtInvert,
  input  ext_e             extMode,
  output logic [WIDTH-1:0] shifted
);

  logic [EW-1:0] extWord;
  logic [AW-1:0] effAmt;

  always_comb begin
    unique case (extMode)
      EXT_ZERO:   extWord = {{PAD{1'b0}}, data};
      EXT_SIGN:   extWord = {{PAD{data[WIDTH-1]}}, data};
      EXT_WRAP:   extWord = {data[WIDTH-2:0], data};
      EXT_LOWPAD: extWord = {data, {PAD{1'b0}}};
      default:    extWord = {{PAD{1'b0}}, data};
    endcase
    effAmt = amtInvert ? ~amt : amt;
  end

  // Each stage drops the bits that no later stage can bring into the low word
  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int STEP = 1 << (AW - 1 - s);
    localparam int IW   = WIDTH + 2 * STEP - 1;
    localparam int OW   = WIDTH + STEP - 1;
    logic [IW-1:0] din;
    logic [OW-1:0] dout;
    if (s == 0) begin : g_first
      assign din = extWord;
    end else begin : g_next
      assign din = g_stage[s-1].dout;
    end
    assign dout = effAmt[AW-1-s] ? din[STEP +: OW] : din[OW-1:0];
  end

  assign shifted = g_stage[AW-1].dout;

  logic [WIDTH-1:0] hiMask;
  logic [WIDTH-1:0] loMask;
  always_comb begin
    hiMask = ~({WIDTH{1'b1}} >> amt);
    loMask = ~({WIDTH{1'b1}} << amt);
  end

  // R7: bits vacated by a left shift hold zeros
  always_comb begin
    a_r7_left_low_zero: assert (extMode != EXT_LOWPAD || (shifted & loMask) == '0)
      else $error("a_r7_left_low_zero: low vacated bits not zero");
  end

  // R9: bits vacated by an arithmetic right shift copy the sign
  always_comb begin
    a_r9_sign_fill: assert (extMode != EXT_SIGN ||
                            (shifted & hiMask) == (data[WIDTH-1] ? hiMask : '0))
      else $error("a_r9_sign_fill: upper vacated bits do not match sign");
  end

  // R10: a rotate by zero returns the word unchanged
  always_comb begin
    a_r10_rotate_zero: assert (extMode != EXT_WRAP || amt != '0 || shifted == data)
      else $error("a_r10_rotate_zero: zero rotate altered the word");
  end

endmodule

// File: rtl/mfalu_datapath.sv
module mfalu_datapath
  import mfalu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [AW-1:0]    shAmt,
  input  strobe_t          strobes,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             ovfFlag
);

  logic [WIDTH-1:0] sum;
  logic             addOvf;
  logic [WIDTH-1:0] shiftOut;
  logic [WIDTH-1:0] logicOut;
  logic [WIDTH-1:0] sltOut;

  mfalu_addsub #(.WIDTH(WIDTH)) i_addsub (
    .a       (opA),
    .b       (opB),
    .invB    (strobes.invB),
    .carryIn (strobes.carryIn),
    .sum     (sum),
    .ovf     (addOvf)
  );

  mfalu_shifter #(.WIDTH(WIDTH)) i_shifter (
    .data      (opA),
    .amt       (shAmt),
    .amtInvert (strobes.amtInvert),
    .extMode   (strobes.extMode),
    .shifted   (shiftOut)
  );

  always_comb begin
    unique case (strobes.logicOp)
      LOG_AND: logicOut = opA & opB;
      LOG_OR:  logicOut = opA | opB;
      LOG_NOR: logicOut = ~(opA | opB);
      LOG_XOR: logicOut = opA ^ opB;
      default: logicOut = opA & opB;
    endcase
    sltOut = {{(WIDTH-1){1'b0}}, sum[WIDTH-1] ^ addOvf};
  end

  // One-hot AND-OR result select
  always_comb begin
    result = ({WIDTH{strobes.pick[PICK_SHIFT]}} & shiftOut)
           | ({WIDTH{strobes.pick[PICK_SLT]}}   & sltOut)
           | ({WIDTH{strobes.pick[PICK_ARITH]}} & sum)
           | ({WIDTH{strobes.pick[PICK_LOGIC]}} & logicOut);
    zeroFlag = ~|result;
    ovfFlag  = addOvf & strobes.ovfEnable;
  end

  // R3: exactly one unit drives the result
  always_comb begin
    a_r3_one_unit: assert ($onehot(strobes.pick))
      else $error("a_r3_one_unit: result pick is not one-hot");
  end

  // R4: compare result carries nothing above bit 0
  always_comb begin
    a_r4_slt_upper_zero: assert (!strobes.pick[PICK_SLT] || result[WIDTH-1:1] == '0)
      else $error("a_r4_slt_upper_zero: compare result has upper bits set");
  end

endmodule

// File: rtl/mfalu.sv
module mfalu
  import mfalu_pkg::*;
(
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [4:0]  shAmt,
  input  logic [1:0]  unitSel,
  input  logic [1:0]  logicSel,
  input  logic [1:0]  shiftSel,
  input  logic        subSel,
  output logic [31:0] result,
  output logic        zeroFlag,
  output logic        ovfFlag
);

  strobe_t strobes;

  mfalu_ctrl i_ctrl (
    .unitSel  (unitSel),
    .logicSel (logicSel),
    .shiftSel (shiftSel),
    .subSel   (subSel),
    .strobes  (strobes)
  );

  mfalu_datapath #(.WIDTH(32)) i_datapath (
    .opA      (opA),
    .opB      (opB),
    .shAmt    (shAmt),
    .strobes  (strobes),
    .result   (result),
    .zeroFlag (zeroFlag),
    .ovfFlag  (ovfFlag)
  );

  // R5: shift and logic units never report overflow
  always_comb begin
    a_r5_no_overflow: assert (!(unitSel == UNIT_SHIFT || unitSel == UNIT_LOGIC) || !ovfFlag)
      else $error("a_r5_no_overflow: overflow raised outside add/compare");
  end

endmodule

// File: tb/test_mfalu.sv
module test_mfalu;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [4:0]  shAmt = '0;
  logic [1:0]  unitSel = '0;
  logic [1:0]  logicSel = '0;
  logic [1:0]  shiftSel = '0;
  logic        subSel = 1'b0;
  logic [31:0] result;
  logic        zeroFlag;
  logic        ovfFlag;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  mfalu i_mfalu (
    .opA(opA), .opB(opB), .shAmt(shAmt), .unitSel(unitSel),
    .logicSel(logicSel), .shiftSel(shiftSel), .subSel(subSel),
    .result(result), .zeroFlag(zeroFlag), .ovfFlag(ovfFlag)
  );

  // Behavioural reference
  logic [31:0] expRes;
  logic        expOvf;
  string       resTag;

  task automatic model();
    longint sa, sb, diff, tot;
    int k;
    sa = longint'($signed(opA));
    sb = longint'($signed(opB));
    k  = int'(shAmt);
    expOvf = 1'b0;
    case (unitSel)
      2'b11: begin
        resTag = "R1";
        case (logicSel)
          2'b00: expRes = opA & opB;
          2'b01: expRes = opA | opB;
          2'b10: expRes = ~(opA | opB);
          default: expRes = opA ^ opB;
        endcase
      end
      2'b10: begin
        resTag = "R2";
        tot = subSel ? (sa - sb) : (sa + sb);
        expRes = tot[31:0];
        expOvf = (tot > 64'sd2147483647) || (tot < -64'sd2147483648);
      end
      2'b01: begin
        resTag = "R4";
        diff = sa - sb;
        expOvf = (diff > 64'sd2147483647) || (diff < -64'sd2147483648);
        expRes = (sa < sb) ? 32'd1 : 32'd0;
      end
      default: begin
        case (shiftSel)
          2'b00: begin resTag = "R7";  expRes = opA << k; end
          2'b10: begin resTag = "R8";  expRes = opA >> k; end
          2'b01: begin resTag = "R9";  expRes = 32'($signed(opA) >>> k); end
          default: begin
            resTag = "R10";
            expRes = (k == 0) ? opA : ((opA >> k) | (opA << (32 - k)));
          end
        endcase
      end
    endcase
  endtask

  task automatic check(input string extra);
    model();
    @(negedge clk);
    checks++;
    if (result !== expRes) begin
      fails++;
      $display("FAIL %s %s result: actual %h expected %h", resTag, extra, result, expRes);
    end
    checks++;
    if (zeroFlag !== (expRes == 32'd0)) begin
      fails++;
      $display("FAIL R6 %s zeroFlag: actual %b expected %b", extra, zeroFlag, expRes == 32'd0);
    end
    checks++;
    if (ovfFlag !== expOvf) begin
      fails++;
      $display("FAIL R5 %s ovfFlag: actual %b expected %b", extra, ovfFlag, expOvf);
    end
  endtask

  task automatic apply(input logic [1:0] u, input logic [1:0] lg, input logic [1:0] sh,
                       input logic sb, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] amt, input string extra);
    @(posedge clk);
    #1;
    unitSel = u; logicSel = lg; shiftSel = sh; subSel = sb;
    opA = a; opB = b; shAmt = amt;
    check(extra);
  endtask

  initial begin
    // Idle state: all-zero inputs give a zero AND-shift result (R6)
    check("idle state R6");

    // R1 logic functions
    for (int f = 0; f < 4; f++)
      apply(2'b11, 2'(f), 2'b00, 1'b0, 32'hF0F0_1234, 32'hFF00_5678, 5'd3, "R1 logic op");

    // R2 and R5 limits
    apply(2'b10, 2'b00, 2'b00, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, "R2 add overflow");
    apply(2'b10, 2'b00, 2'b00, 1'b1, 32'h8000_0000, 32'h0000_0001, 5'd0, "R2 sub overflow");
    apply(2'b10, 2'b00, 2'b00, 1'b1, 32'h1234_5678, 32'h1234_5678, 5'd0, "R2 sub to zero R6");
    apply(2'b10, 2'b00, 2'b00, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, "R2 carry out no ovf");

    // R4 compare, both subSel values, overflow cases
    for (int s = 0; s < 2; s++) begin
      apply(2'b01, 2'b00, 2'b00, 1'(s), 32'h8000_0000, 32'h0000_0001, 5'd0, "R4 min vs one");
      apply(2'b01, 2'b00, 2'b00, 1'(s), 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R4 max vs minus one");
      apply(2'b01, 2'b00, 2'b00, 1'(s), 32'h0000_0005, 32'h0000_0005, 5'd0, "R4 equal");
    end

    // R3: same operands through every unit
    for (int u = 0; u < 4; u++)
      apply(2'(u), 2'b01, 2'b10, 1'b1, 32'hC000_0003, 32'h4000_0001, 5'd1, "R3 unit sweep");

    // R7-R10: every amount for every shift kind, on a sign-set word
    for (int sh = 0; sh < 4; sh++)
      for (int k = 0; k < 32; k++)
        apply(2'b00, 2'b00, 2'(sh), 1'b0, 32'h9E37_79B9, 32'h0, 5'(k), "shift sweep R7 R8 R9 R10");

    // Random patterns across all units
    for (int n = 0; n < 3000; n++)
      apply(2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
            $urandom, $urandom, 5'($urandom), "random");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule